// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Controller

This block is a small register-mapped port of ten general-purpose pins combined with an edge-sensitive interrupt collector. Each pin has a direction bit and an output data bit. Reading the data address returns the state the pads actually show, after synchronization. There are fifteen interrupt sources: the ten pins plus five on-chip status lines (converter ready, touch comparator plus, touch comparator minus, telecom clip detect, audio clip detect).

Every source passes through a synchronizer before edge detection. Rising and falling edges are enabled separately for each source. An enabled edge sets a sticky flag, and the single interrupt output is the OR of all flags. A flag is cleared when its bit in the value written to the clear address goes from 0 to 1 compared with the value written there before. A further control bit in the direction register drives the hold-low control of a neighbouring serial data output.

The host reaches the block over a plain synchronous bus with an address, a write strobe, write data and combinational read data.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset, addresses 1, 2, 3 and 4 read 0, every pin is an input (pin_oe all 0), irq is 0 and sdo_hold_low is 0.
- R2: Writing address 1 sets pin_oe to bits 9:0 of the written word, where 1 means output. Writing address 0 sets pin_out to bits 9:0 of the written word.
- R3: A read of address 0 returns the synchronized level on pin_in in bits 9:0, not the last written data.
- R4: In addresses 2, 3 and 4, bits 9:0 belong to pins 0..9 and bits 11..15 belong to aux_src[0]..aux_src[4]. Bit 10, and bits 14:10 of address 1, always read 0.
- R5: Bit 15 of address 1 is stored, reads back, and drives sdo_hold_low.
- R6: When a source rises from 0 to 1 and its bit in address 2 (rising enable) is 1, its flag is set. It stays set after the source returns to its old level.
- R7: When a source falls from 1 to 0 and its bit in address 3 (falling enable) is 1, its flag is set.
- R8: An edge whose polarity is not enabled for its source leaves the flag unchanged.
- R9: A write to address 4 clears exactly those flags whose bit is 1 in the new word and was 0 in the word previously written to address 4. Writing 1 again without an intervening 0 has no effect.
- R10: If an enabled edge and a clear of the same flag take effect on the same clock edge, the flag ends up set.
- R11: irq is 1 exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register select, 0..4 |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 10 | Pad levels as seen by the block |
| pin_out | output | 10 | Output data for each pad |
| pin_oe | output | 10 | Output enable for each pad |
| aux_src | input | 5 | Converter ready, touch plus, touch minus, telecom clip, audio clip |
| sdo_hold_low | output | 1 | 1 holds the serial data output low, 0 lets it float |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: ten pins, five auxiliary sources placed from bit 11, the hold-low control in bit 15 and a two-stage synchronizer. This layout leaves bit 10 as a gap that must read 0. The fixed synchronizer depth lets the bench place a clear write on exactly the clock edge where an edge sets a flag, so it can check that the set wins. The pad model loops pin_out back onto pin_in wherever pin_oe is 1, so data reads show pins in both directions.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

   localparam int BUS_W = 16;

   typedef enum logic [2:0] {
      SEL_DATA = 3'd0,
      SEL_DIR  = 3'd1,
      SEL_RISE = 3'd2,
      SEL_FALL = 3'd3,
      SEL_FLAG = 3'd4
   } reg_sel_e;

   // Mask with ones at bit positions [lsb, lsb+width)
   function automatic logic [BUS_W-1:0] field_mask(input int lsb, input int width);
      logic [BUS_W-1:0] m;
      m = '0;
      for (int i = 0; i < BUS_W; i++) begin
         if (i >= lsb && i < lsb + width) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("pin_event_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
         end else begin
            st_q[0] <= d;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
         end
      end

      assign q = st_q[STAGES-1];
   end

endmodule

// File: rtl/pin_event_flags.sv
module pin_event_flags
   import pin_event_pkg::*;
#(
   parameter logic [BUS_W-1:0] SRC_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] src,
   input  logic [BUS_W-1:0] rise_en,
   input  logic [BUS_W-1:0] fall_en,
   input  logic [BUS_W-1:0] clr_hit,
   output logic [BUS_W-1:0] hit,
   output logic [BUS_W-1:0] flags
);

   logic [BUS_W-1:0] prev_q;
   logic [BUS_W-1:0] flag_q;
   logic [BUS_W-1:0] rise_ev;
   logic [BUS_W-1:0] fall_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= src & SRC_MASK;
   end

   always_comb begin
      rise_ev = src & ~prev_q & SRC_MASK;
      fall_ev = ~src & prev_q & SRC_MASK;
      hit     = (rise_ev & rise_en) | (fall_ev & fall_en);
   end

   // A new edge is ORed in after the clear is applied, so the set wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr_hit) | hit;
   end

   assign flags = flag_q;

endmodule

// File: rtl/pin_event_regs.sv
module pin_event_regs
   import pin_event_pkg::*;
#(
   parameter int               NPIN     = 10,
   parameter int               SDO_BIT  = 15,
   parameter logic [BUS_W-1:0] SRC_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [NPIN-1:0]  pin_now,
   input  logic [BUS_W-1:0] flags,
   output logic [NPIN-1:0]  data_o,
   output logic [NPIN-1:0]  dir_o,
   output logic             sdo_o,
   output logic [BUS_W-1:0] rise_en,
   output logic [BUS_W-1:0] fall_en,
   output logic [BUS_W-1:0] clr_hit
);

   logic [NPIN-1:0]  data_q;
   logic [NPIN-1:0]  dir_q;
   logic             sdo_q;
   logic [BUS_W-1:0] ren_q;
   logic [BUS_W-1:0] fen_q;
   logic [BUS_W-1:0] clr_last_q;
   logic             flag_wr;

   assign flag_wr = bus_wr && (bus_addr == SEL_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q     <= '0;
         dir_q      <= '0;
         sdo_q      <= 1'b0;
         ren_q      <= '0;
         fen_q      <= '0;
         clr_last_q <= '0;
      end else if (bus_wr) begin
         case (reg_sel_e'(bus_addr))
            SEL_DATA: data_q <= bus_wdata[NPIN-1:0];
            SEL_DIR: begin
               dir_q <= bus_wdata[NPIN-1:0];
               sdo_q <= bus_wdata[SDO_BIT];
            end
            SEL_RISE: ren_q      <= bus_wdata & SRC_MASK;
            SEL_FALL: fen_q      <= bus_wdata & SRC_MASK;
            SEL_FLAG: clr_last_q <= bus_wdata & SRC_MASK;
            default: ;
         endcase
      end
   end

   // Clear only where the written bit rises against the last written value
   assign clr_hit = flag_wr ? (bus_wdata & ~clr_last_q & SRC_MASK) : '0;

   always_comb begin
      bus_rdata = '0;
      case (reg_sel_e'(bus_addr))
         SEL_DATA: bus_rdata[NPIN-1:0] = pin_now;
         SEL_DIR: begin
            bus_rdata[NPIN-1:0] = dir_q;
            bus_rdata[SDO_BIT]  = sdo_q;
         end
         SEL_RISE: bus_rdata = ren_q;
         SEL_FALL: bus_rdata = fen_q;
         SEL_FLAG: bus_rdata = flags;
         default:  bus_rdata = '0;
      endcase
   end

   assign data_o  = data_q;
   assign dir_o   = dir_q;
   assign sdo_o   = sdo_q;
   assign rise_en = ren_q;
   assign fall_en = fen_q;

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
   import pin_event_pkg::*;
#(
   parameter int NPIN        = 10,
   parameter int NAUX        = 5,
   parameter int AUX_LSB     = 11,
   parameter int SDO_BIT     = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [NPIN-1:0]  pin_in,
   output logic [NPIN-1:0]  pin_out,
   output logic [NPIN-1:0]  pin_oe,
   input  logic [NAUX-1:0]  aux_src,
   output logic             sdo_hold_low,
   output logic             irq
);

   localparam logic [BUS_W-1:0] PIN_MASK = field_mask(0, NPIN);
   localparam logic [BUS_W-1:0] AUX_MASK = field_mask(AUX_LSB, NAUX);
   localparam logic [BUS_W-1:0] SRC_MASK = PIN_MASK | AUX_MASK;

   if (NPIN < 1 || NPIN > AUX_LSB) begin : g_bad_npin
      $error("pin_event_ctrl: pin field must fit below the auxiliary field");
   end
   if (NAUX < 1 || AUX_LSB + NAUX > BUS_W) begin : g_bad_aux
      $error("pin_event_ctrl: auxiliary field exceeds the bus word");
   end
   if (SDO_BIT < NPIN || SDO_BIT >= BUS_W) begin : g_bad_sdo
      $error("pin_event_ctrl: hold-low bit collides with the pin field");
   end

   logic [BUS_W-1:0] src_raw;
   logic [BUS_W-1:0] src_sync;
   logic [BUS_W-1:0] rise_en;
   logic [BUS_W-1:0] fall_en;
   logic [BUS_W-1:0] clr_hit;
   logic [BUS_W-1:0] hit_vec;
   logic [BUS_W-1:0] flag_vec;
   logic [NPIN-1:0]  data_q;
   logic [NPIN-1:0]  dir_q;
   logic             sdo_q;

   always_comb begin
      src_raw                  = '0;
      src_raw[NPIN-1:0]        = pin_in;
      src_raw[AUX_LSB +: NAUX] = aux_src;
   end

   pin_event_sync #(
      .W      (BUS_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_raw),
      .q     (src_sync)
   );

   pin_event_regs #(
      .NPIN     (NPIN),
      .SDO_BIT  (SDO_BIT),
      .SRC_MASK (SRC_MASK)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_now   (src_sync[NPIN-1:0]),
      .flags     (flag_vec),
      .data_o    (data_q),
      .dir_o     (dir_q),
      .sdo_o     (sdo_q),
      .rise_en   (rise_en),
      .fall_en   (fall_en),
      .clr_hit   (clr_hit)
   );

   pin_event_flags #(
      .SRC_MASK (SRC_MASK)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_sync),
      .rise_en (rise_en),
      .fall_en (fall_en),
      .clr_hit (clr_hit),
      .hit     (hit_vec),
      .flags   (flag_vec)
   );

   assign pin_out      = data_q;
   assign pin_oe       = dir_q;
   assign sdo_hold_low = sdo_q;
   assign irq          = |flag_vec;

endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk
   import pin_event_pkg::*;
#(
   parameter int NPIN    = 10,
   parameter int NAUX    = 5,
   parameter int AUX_LSB = 11,
   parameter int SDO_BIT = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       bus_addr,
   input logic             bus_wr,
   input logic [BUS_W-1:0] bus_wdata,
   input logic [BUS_W-1:0] bus_rdata,
   input logic [NPIN-1:0]  pin_oe,
   input logic             sdo_hold_low,
   input logic             irq,
   input logic [BUS_W-1:0] hit_vec,
   input logic [BUS_W-1:0] flag_vec,
   input logic [BUS_W-1:0] clr_hit
);

   localparam logic [BUS_W-1:0] SRC_MASK = field_mask(0, NPIN) | field_mask(AUX_LSB, NAUX);
   localparam logic [BUS_W-1:0] DIR_MASK = field_mask(0, NPIN) | field_mask(SDO_BIT, 1);

   AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SEL_DIR) |=> (pin_oe == $past(bus_wdata[NPIN-1:0]))); // R2

   AST_RISE_EN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SEL_RISE) |=>
         (bus_addr != SEL_RISE || bus_rdata == ($past(bus_wdata) & SRC_MASK))); // R4

   AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SEL_DIR) ? ((bus_rdata & ~DIR_MASK) == '0)
                            : ((bus_addr == SEL_DATA) || ((bus_rdata & ~SRC_MASK) == '0))); // R4

   AST_SDO_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SEL_DIR) |=> (sdo_hold_low == $past(bus_wdata[SDO_BIT]))); // R5

   AST_FLAG_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flag_vec) & ~flag_vec & ~$past(clr_hit)) == '0)); // R9

   AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec != '0) |=> ((flag_vec & $past(hit_vec)) == $past(hit_vec))); // R10

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(hit_vec != '0)); // R11

endmodule

bind pin_event_ctrl pin_event_chk #(
   .NPIN    (NPIN),
   .NAUX    (NAUX),
   .AUX_LSB (AUX_LSB),
   .SDO_BIT (SDO_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wr       (bus_wr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .pin_oe       (pin_oe),
   .sdo_hold_low (sdo_hold_low),
   .irq          (irq),
   .hit_vec      (hit_vec),
   .flag_vec     (flag_vec),
   .clr_hit      (clr_hit)
);

// File: tb/pin_event_ctrl_test.sv
`timescale 1ns/1ps
module pin_event_ctrl_test;

   localparam int NP = 10;
   localparam int NX = 5;

   typedef struct packed {
      logic [9:0]  pa;
      logic [9:0]  pb;
      logic [4:0]  xa;
      logic [4:0]  xb;
      logic [15:0] ren;
      logic [15:0] fen;
   } vec_t;

   // Source levels before/after, and the enables in force
   localparam vec_t VECS [8] = '{
      {10'h000, 10'h3FF, 5'h00, 5'h00, 16'h03FF, 16'h0000},  // R6 all pins rise
      {10'h3FF, 10'h000, 5'h00, 5'h00, 16'h03FF, 16'h0000},  // R8 fall, only rise on
      {10'h3FF, 10'h000, 5'h00, 5'h00, 16'h0000, 16'h03FF},  // R7 all pins fall
      {10'h0F0, 10'h00F, 5'h00, 5'h00, 16'hFFFF, 16'hFFFF},  // R6 R7 both polarities
      {10'h000, 10'h000, 5'h00, 5'h1F, 16'hF800, 16'h0000},  // R4 aux rise
      {10'h000, 10'h000, 5'h1F, 5'h0A, 16'h0000, 16'hFFFF},  // R4 R7 aux fall
      {10'h155, 10'h2AA, 5'h00, 5'h00, 16'h00F0, 16'h0000},  // R6 partial enable
      {10'h000, 10'h200, 5'h00, 5'h04, 16'h2001, 16'h0000}   // R8 pin 9 not enabled
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [NP-1:0] pin_in;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic [NP-1:0] ext_pins = '0;
   logic [NX-1:0] aux_src = '0;
   logic        sdo_hold_low;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_pins);

   pin_event_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pin_in       (pin_in),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe),
      .aux_src      (aux_src),
      .sdo_hold_low (sdo_hold_low),
      .irq          (irq)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_all();
      bus_write(3'd4, 16'h0000);
      bus_write(3'd4, 16'hFFFF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      logic [15:0] sa, sb, ex;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 1; a <= 4; a++) begin
         bus_read(3'(a), rd);
         check("R1 reg reset", rd, 16'h0000);
      end
      check("R1 oe reset", 16'(pin_oe), 16'h0000);
      check("R1 irq reset", 16'(irq), 16'h0000);
      check("R1 sdo reset", 16'(sdo_hold_low), 16'h0000);

      // Table walk: R4 R6 R7 R8 R11
      for (int i = 0; i < 8; i++) begin
         bus_write(3'd2, VECS[i].ren);
         bus_write(3'd3, VECS[i].fen);
         ext_pins = VECS[i].pa; aux_src = VECS[i].xa;
         settle();
         clear_all();
         ext_pins = VECS[i].pb; aux_src = VECS[i].xb;
         settle();
         sa = {VECS[i].xa, 1'b0, VECS[i].pa};
         sb = {VECS[i].xb, 1'b0, VECS[i].pb};
         ex = ((sb & ~sa) & VECS[i].ren) | ((sa & ~sb) & VECS[i].fen);
         bus_read(3'd4, rd);
         check($sformatf("R6/R7/R8 vector %0d flags", i), rd, ex);
         check($sformatf("R11 vector %0d irq", i), 16'(irq), 16'(ex != 0));
      end
      bus_write(3'd2, 16'h0000);
      bus_write(3'd3, 16'h0000);
      clear_all();

      // R2 R3 direction, data and live read
      ext_pins = 10'h111;
      bus_write(3'd1, 16'h00A5);
      bus_write(3'd0, 16'h03C3);
      check("R2 oe", 16'(pin_oe), 16'h00A5);
      check("R2 out", 16'(pin_out), 16'h03C3);
      settle();
      bus_read(3'd0, rd);
      check("R3 live read", rd, 16'((10'h0A5 & 10'h3C3) | (~10'h0A5 & 10'h111)));

      // R4 R5 unused bits and hold-low control
      bus_write(3'd1, 16'hFFFF);
      bus_read(3'd1, rd);
      check("R4 dir readback", rd, 16'h83FF);
      check("R5 sdo set", 16'(sdo_hold_low), 16'h0001);
      bus_write(3'd2, 16'hFFFF);
      bus_read(3'd2, rd);
      check("R4 enable gap", rd, 16'hFBFF);
      bus_write(3'd1, 16'h0000);
      check("R5 sdo clear", 16'(sdo_hold_low), 16'h0000);
      bus_write(3'd2, 16'h0000);
      ext_pins = '0;
      settle();

      // R9 clear on 0->1 of the written clear bit only
      bus_write(3'd2, 16'h0800);
      aux_src = 5'h01;
      settle();
      bus_read(3'd4, rd);
      check("R9 flag set", rd, 16'h0800);
      bus_write(3'd4, 16'hFFFF);
      bus_read(3'd4, rd);
      check("R9 repeat 1 no effect", rd, 16'h0800);
      check("R11 irq high", 16'(irq), 16'h0001);
      bus_write(3'd4, 16'h0000);
      bus_read(3'd4, rd);
      check("R9 write 0 no effect", rd, 16'h0800);
      bus_write(3'd4, 16'h0800);
      bus_read(3'd4, rd);
      check("R9 cleared", rd, 16'h0000);
      check("R11 irq low", 16'(irq), 16'h0000);

      // R10 set and clear on the same edge
      bus_write(3'd4, 16'h0000);
      aux_src = 5'h00;
      settle();
      @(negedge clk); aux_src = 5'h01;        // edge P1: stage 1
      @(negedge clk);                          // edge P2: stage 2, hit
      @(negedge clk);
      bus_addr = 3'd4; bus_wdata = 16'h0800; bus_wr = 1'b1;  // taken at P3
      @(negedge clk); bus_wr = 1'b0;
      bus_read(3'd4, rd);
      check("R10 set wins", rd, 16'h0800);
      clear_all();
      bus_read(3'd4, rd);
      check("R10 later clear", rd, 16'h0000);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule